// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block serves one bank of eight general-purpose pins. A byte-wide register bus lets software set which pins are driven, set the values they drive, and read back the pin levels. Every pin also feeds an interrupt detector. The detector can watch for a level or for an edge, and for either polarity. Each pin can route its input through an optional debounce filter before detection.

Each pin has a mask bit. A latched edge is cleared by writing a one to that pin's bit in a clear register. Software can read two status views: the raw view ignores the mask, and the masked view applies it. The masked bits drive eight per-pin interrupt outputs and one combined output, which is their OR.

To change a pin's trigger mode without false events, software clears the mask, rewrites the mode bits, and then sets the mask again.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, all configuration and data registers are zero, `pin_oe` is 0x00, and `irq_pin` and `irq_any` are low.
- R2: Port window addresses: the output-value register is at 0x00 and the drive-enable register is at 0x10. A drive bit of 1 turns `pin_oe[n]` on, and `pin_out` carries the output-value register. A read of 0x00 returns the output-value bit for driven pins. For undriven pins it returns the synchronised input.
- R3: The mode register is at 0x40 and the polarity register is at 0x44. When a pin's mode bit is 0, its raw status bit follows the qualified pin level and is not latched. A polarity bit of 1 makes the pin active-high; 0 makes it active-low. Writes to the clear register do not change this bit.
- R4: When a pin's mode bit is 1, a qualified edge sets a latch. Polarity 1 selects the rising edge and 0 selects the falling edge. An edge of the other direction leaves the latch unchanged. The latch holds until it is cleared.
- R5: A write to the clear register at 0x48 clears every edge latch whose bit is 1 and leaves the others as they are. If a new edge arrives in the same cycle as the clear of that pin, the new edge sets the latch.
- R6: The mask register is at 0x4C. The masked status at 0x50 equals the raw status at 0x54 ANDed with the mask. `irq_pin[n]` is masked status bit n, and `irq_any` is the OR of all masked bits.
- R7: No edge is latched while the pin's mask bit is 0. If an edge arrived while the mask was 0, setting the mask bit afterwards does not raise an interrupt.
- R8: With the filter off, a change applied to a pin first shows in the edge latch after the third rising clock edge. It does not show after the second.
- R9: When a pin's filter bit at 0x58 is 1, the pin level is accepted only after it has been stable for DEB_CYCLES cycles (default 16). A shorter pulse causes no event.
- R10: A read of the clear register returns zero. Writes to the two status addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Values to drive on the pins |
| pin_oe | output | 8 | Per-pin drive enable |
| irq_pin | output | 8 | Per-pin masked interrupt |
| irq_any | output | 1 | OR of all masked interrupts |

## Verification
The hardest case to produce is a new edge and a clear of the same pin landing in the same clock cycle. The edge reaches the latch input only after the two synchroniser stages. The bench therefore changes the pin on a falling clock edge and lets two rising edges pass. It then places the clear write so that the bus samples it on the third rising edge, which is the same edge that loads the new event. The filter case is reached in a similar way: the bench drives pulses just shorter than the filter window and checks that the latch stays clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned NPIN = 8;

  // port window
  localparam logic [6:0] A_OUTVAL = 7'h00;
  localparam logic [6:0] A_DRIVE  = 7'h10;
  // interrupt window, base 0x40
  localparam logic [6:0] IRQ_BASE = 7'h40;
  localparam logic [6:0] A_MODE   = IRQ_BASE + 7'h00;
  localparam logic [6:0] A_POL    = IRQ_BASE + 7'h04;
  localparam logic [6:0] A_CLR    = IRQ_BASE + 7'h08;
  localparam logic [6:0] A_MASK   = IRQ_BASE + 7'h0C;
  localparam logic [6:0] A_MSTAT  = IRQ_BASE + 7'h10;
  localparam logic [6:0] A_RSTAT  = IRQ_BASE + 7'h14;
  localparam logic [6:0] A_FILT   = IRQ_BASE + 7'h18;

  // level match for one pin: pol 1 = high active
  function automatic logic level_hit(input logic pol, input logic lvl);
    return pol ? lvl : ~lvl;
  endfunction

  // edge match for one pin: pol 1 = rising
  function automatic logic edge_hit(input logic pol, input logic now_v,
                                    input logic old_v);
    return pol ? (now_v & ~old_v) : (~now_v & old_v);
  endfunction

  // value seen on a read of the output-value register
  function automatic logic [NPIN-1:0] port_view(input logic [NPIN-1:0] drv,
                                                input logic [NPIN-1:0] outv,
                                                input logic [NPIN-1:0] inv);
    return (drv & outv) | (~drv & inv);
  endfunction

endpackage

// File: rtl/gpio_pin_cond.sv
module gpio_pin_cond #(
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic filt_en,
  output logic sync_o,
  output logic qual_o
);
  localparam int unsigned CNT_W = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic s1_q, s2_q;
  logic deb_q;
  logic [CNT_W-1:0] cnt_q;
  logic differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_raw;
      s2_q <= s1_q;
    end
  end

  assign differs = (s2_q != deb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_q <= 1'b0;
      cnt_q <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      deb_q <= s2_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sync_o = s2_q;
  assign qual_o = filt_en ? deb_q : s2_q;

  // R9: the filtered level never moves while the input agrees with it
  p_filter_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q == deb_q) |=> $stable(deb_q));

endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic mode_edge,
  input  logic pol,
  input  logic mask,
  input  logic clr,
  output logic raw_o
);
  logic prev_q;
  logic latch_q;
  logic edge_evt;
  logic capture;
  logic latch_d;

  assign edge_evt = edge_hit(pol, qual, prev_q);
  assign capture  = edge_evt & mask & mode_edge;

  always_comb begin
    if (!mode_edge) latch_d = 1'b0;
    else            latch_d = (latch_q & ~clr) | capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= qual;
      latch_q <= latch_d;
    end
  end

  assign raw_o = mode_edge ? latch_q : level_hit(pol, qual);

  // R7: a masked pin never gains a latched event
  p_no_capture_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask && !latch_q) |=> !latch_q);
  // R5: a clear without a coincident event empties the latch
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_evt) |=> !latch_q);
  // R5: a qualifying event wins over a same-cycle clear
  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && mask && mode_edge) |=> latch_q);
  // R4: a latched event holds until cleared or the mode leaves edge
  p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr && mode_edge) |=> latch_q);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic [7:0] irq_pin,
  output logic       irq_any
);
  logic [NPIN-1:0] outv_q, drive_q, mode_q, pol_q, mask_q, filt_q;
  logic [NPIN-1:0] clr_pulse;
  logic [NPIN-1:0] sync_v, qual_v, raw_v, mstat_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outv_q  <= '0;
      drive_q <= '0;
      mode_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      filt_q  <= '0;
    end else if (bus_we) begin
      unique case (bus_addr)
        A_OUTVAL: outv_q  <= bus_wdata;
        A_DRIVE:  drive_q <= bus_wdata;
        A_MODE:   mode_q  <= bus_wdata;
        A_POL:    pol_q   <= bus_wdata;
        A_MASK:   mask_q  <= bus_wdata;
        A_FILT:   filt_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign clr_pulse = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    gpio_pin_cond #(.DEB_CYCLES(DEB_CYCLES)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_raw (pin_in[n]),
      .filt_en (filt_q[n]),
      .sync_o  (sync_v[n]),
      .qual_o  (qual_v[n])
    );
    gpio_irq_det u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual      (qual_v[n]),
      .mode_edge (mode_q[n]),
      .pol       (pol_q[n]),
      .mask      (mask_q[n]),
      .clr       (clr_pulse[n]),
      .raw_o     (raw_v[n])
    );
  end

  assign mstat_v = raw_v & mask_q;

  always_comb begin
    unique case (bus_addr)
      A_OUTVAL: bus_rdata = port_view(drive_q, outv_q, sync_v);
      A_DRIVE:  bus_rdata = drive_q;
      A_MODE:   bus_rdata = mode_q;
      A_POL:    bus_rdata = pol_q;
      A_MASK:   bus_rdata = mask_q;
      A_MSTAT:  bus_rdata = mstat_v;
      A_RSTAT:  bus_rdata = raw_v;
      A_FILT:   bus_rdata = filt_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = outv_q;
  assign pin_oe  = drive_q;
  assign irq_pin = mstat_v;
  assign irq_any = |mstat_v;

  // R6: the combined line agrees with the per-pin lines
  p_any_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_pin != 8'h00));
  // R6: no per-pin line is raised for a masked pin
  p_pin_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin & ~mask_q) == 8'h00);

endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, irq_pin;
  logic       irq_any;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.DEB_CYCLES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_any(irq_any));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic clks(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 irq_pin", irq_pin, 8'h00);
    chk("R1 irq_any", {7'd0, irq_any}, 8'h00);
    rd(7'h40, v); chk("R1 mode", v, 8'h00);
    rd(7'h4C, v); chk("R1 mask", v, 8'h00);
    rd(7'h10, v); chk("R1 drive", v, 8'h00);
  endtask

  task automatic t_port;
    logic [7:0] v;
    wr(7'h10, 8'h0F);
    wr(7'h00, 8'hA5);
    pin_in = 8'h30;
    clks(4);
    chk("R2 oe", pin_oe, 8'h0F);
    chk("R2 out", pin_out, 8'hA5);
    rd(7'h00, v); chk("R2 readback", v, 8'h35);
    pin_in = 8'h00;
    wr(7'h10, 8'h00);
    clks(4);
    rd(7'h00, v); chk("R2 all inputs", v, 8'h00);
  endtask

  task automatic t_regmap;
    logic [7:0] v;
    wr(7'h40, 8'hC3);
    rd(7'h40, v); chk("R10 mode rb", v, 8'hC3);
    wr(7'h50, 8'hFF);
    wr(7'h54, 8'hFF);
    rd(7'h50, v); chk("R10 mstat ro", v, 8'h00);
    rd(7'h48, v); chk("R10 clr reads 0", v, 8'h00);
    wr(7'h40, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] v;
    wr(7'h44, 8'h02);
    wr(7'h4C, 8'h02);
    clks(4);
    rd(7'h54, v); chk("R3 low idle", v & 8'h02, 8'h00);
    pin_in[1] = 1'b1;
    clks(4);
    rd(7'h54, v); chk("R3 high active", v & 8'h02, 8'h02);
    chk("R6 irq_pin level", irq_pin, 8'h02);
    chk("R6 irq_any level", {7'd0, irq_any}, 8'h01);
    wr(7'h48, 8'h02);
    rd(7'h54, v); chk("R3 clr no effect", v & 8'h02, 8'h02);
    pin_in[1] = 1'b0;
    clks(4);
    rd(7'h54, v); chk("R3 follows level", v & 8'h02, 8'h00);
    wr(7'h4C, 8'h00);
    wr(7'h44, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] v;
    wr(7'h40, 8'h01);
    wr(7'h44, 8'h01);
    wr(7'h4C, 8'h01);
    clks(3);
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rd(7'h54, v); chk("R8 not after 2 edges", v & 8'h01, 8'h00);
    @(posedge clk); #1;
    rd(7'h54, v); chk("R8 after 3 edges", v & 8'h01, 8'h01);
    pin_in[0] = 1'b0;
    clks(5);
    rd(7'h54, v); chk("R4 latch held", v & 8'h01, 8'h01);
    wr(7'h48, 8'hFE);
    rd(7'h54, v); chk("R5 zero bits", v & 8'h01, 8'h01);
    wr(7'h48, 8'h01);
    rd(7'h54, v); chk("R5 clear", v & 8'h01, 8'h00);
    wr(7'h44, 8'h00);
    pin_in[0] = 1'b1;
    clks(5);
    rd(7'h54, v); chk("R4 rise ignored falling", v & 8'h01, 8'h00);
    pin_in[0] = 1'b0;
    clks(5);
    rd(7'h54, v); chk("R4 falling latched", v & 8'h01, 8'h01);
    wr(7'h48, 8'h01);
    wr(7'h44, 8'h01);
    pin_in[0] = 1'b1;
    clks(5);
    pin_in[0] = 1'b0;
    clks(5);
    rd(7'h54, v); chk("R4 rising latched", v & 8'h01, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 7'h48; bus_wdata = 8'h01; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(7'h54, v); chk("R5 edge wins", v & 8'h01, 8'h01);
    wr(7'h48, 8'h01);
    rd(7'h54, v); chk("R5 clear after", v & 8'h01, 8'h00);
    pin_in[0] = 1'b0;
    wr(7'h4C, 8'h00);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    wr(7'h40, 8'h04);
    wr(7'h44, 8'h04);
    pin_in[2] = 1'b1;
    clks(5);
    rd(7'h54, v); chk("R7 no capture masked", v & 8'h04, 8'h00);
    wr(7'h4C, 8'h04);
    clks(2);
    rd(7'h54, v); chk("R7 no stale event", v & 8'h04, 8'h00);
    chk("R7 irq_any quiet", {7'd0, irq_any}, 8'h00);
    pin_in[2] = 1'b0;
    clks(5);
    pin_in[2] = 1'b1;
    clks(5);
    chk("R6 irq_pin edge", irq_pin, 8'h04);
    chk("R6 irq_any edge", {7'd0, irq_any}, 8'h01);
    wr(7'h4C, 8'h00);
    rd(7'h50, v); chk("R6 mstat masked", v, 8'h00);
    rd(7'h54, v); chk("R6 raw keeps", v & 8'h04, 8'h04);
    chk("R6 irq_any off", {7'd0, irq_any}, 8'h00);
    wr(7'h48, 8'h04);
    pin_in[2] = 1'b0;
  endtask

  task automatic t_filter;
    logic [7:0] v;
    wr(7'h58, 8'h08);
    wr(7'h40, 8'h08);
    wr(7'h44, 8'h08);
    wr(7'h4C, 8'h08);
    clks(20);
    pin_in[3] = 1'b1;
    clks(8);
    pin_in[3] = 1'b0;
    clks(40);
    rd(7'h54, v); chk("R9 short pulse ignored", v & 8'h08, 8'h00);
    pin_in[3] = 1'b1;
    clks(40);
    rd(7'h54, v); chk("R9 stable accepted", v & 8'h08, 8'h08);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clks(5);
    t_reset();
    rst_n = 1'b1;
    clks(2);
    t_port();
    t_regmap();
    t_level();
    t_edge();
    t_enable();
    t_filter();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule